// File: doc/BRIEF.md
# GPIO Port with Pin Interrupt Controller

This block is one general-purpose I/O port of up to 32 pins behind a small synchronous register bus. Software sets, per pin, an output-enable bit, an input-enable bit and an output data bit. It reads the live (synchronized) pin levels back through the data register. Every pin input passes through a two-flop synchronizer before any logic looks at it.

Each pin can raise an interrupt on one of four trigger types, chosen by a 2-bit field: high level, low level, rising edge or falling edge. No type fires on both edges. A trigger on an unmasked pin sets that pin's pending bit, which software clears by writing 1. A small control slice for the port holds an enable bit, a sticky port-pending bit and a choice between two sample strobes. Edge detection only advances on cycles where the chosen strobe is high. The port drives one combined interrupt line.

The register bus uses a 3-bit word index. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational from the index while `bus_sel` is high and `bus_wr` is low, and is zero otherwise.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads 0, and `pin_oe_o`, `pin_ie_o`, `pin_out_o` and `irq_o` are 0.
- R2: Word 0 is output enable and word 1 is input enable, with bit n for pin n. Both read back as written and drive `pin_oe_o` and `pin_ie_o`. Word 2 written sets the data bits, and `pin_out_o` is data AND output enable.
- R3: Reading word 2 returns the pin levels. A change on `pins_i` is visible there after two rising clock edges, and not after one.
- R4: Trigger types are 2 bits per pin, encoded 00 high level, 01 low level, 10 rising edge, 11 falling edge. Pins 16..31 sit in word 3 and pins 0..15 in word 4, with the field of pin n at bit 2*(n mod 16). Fields of absent pins read 0.
- R5: An edge type sets the pin's pending bit for its edge only. A single edge sets the bit once, so after a clear it stays 0.
- R6: A level type sets pending while its level holds. A clear while the level persists leaves the bit set.
- R7: Pending bits are set only for pins whose mask bit (word 5, bit n) is 1. Unmasking a pin whose level condition holds sets its pending bit.
- R8: Word 6 holds pending bits. Writing 1 to a bit clears it and writing 0 leaves it unchanged.
- R9: Word 7 holds the port slice at bit 5*SLOT: +0 enable, +1 port pending (write 1 to clear), +2 sample select (0 uses `samp_a_i`, 1 uses `samp_b_i`). All other bits read 0.
- R10: `irq_o` is high exactly when enable is 1 and some pin is both pending and unmasked. The port pending bit is set on the edge after `irq_o` is high and stays set until it is cleared.
- R11: Edge detection compares the level against the level held at the last selected-strobe cycle, and only fires on a strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| pins_i | input | NPINS | Pin input levels |
| pin_out_o | output | NPINS | Pin output values |
| pin_oe_o | output | NPINS | Pin output enables |
| pin_ie_o | output | NPINS | Pin input enables |
| samp_a_i | input | 1 | Sample strobe, select 0 |
| samp_b_i | input | 1 | Sample strobe, select 1 |
| irq_o | output | 1 | Combined port interrupt |

## Verification
The hardest case to reach is an edge that happens between strobes. The pin must change while the chosen strobe stays low, and the bench must then show that no pending bit appears. A later strobe pulse must set pending exactly once. The bench reaches this by moving the port to the second strobe while the first stays tied high, holding that second strobe low across a rising edge, and then pulsing it twice. The sweep over every pin and every type also covers the split type words: any swap of the two words or of field positions lands a trigger on the wrong pin.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] A_OE    = 3'd0;
  localparam logic [REG_AW-1:0] A_IE    = 3'd1;
  localparam logic [REG_AW-1:0] A_DAT   = 3'd2;
  localparam logic [REG_AW-1:0] A_THI   = 3'd3;
  localparam logic [REG_AW-1:0] A_TLO   = 3'd4;
  localparam logic [REG_AW-1:0] A_MASK  = 3'd5;
  localparam logic [REG_AW-1:0] A_PEND  = 3'd6;
  localparam logic [REG_AW-1:0] A_CTRL  = 3'd7;

  localparam int SL_EN   = 0;
  localparam int SL_PEND = 1;
  localparam int SL_SEL  = 2;
  localparam int SL_W    = 5;

  typedef enum logic [1:0] {
    TRIG_HIGH = 2'b00,
    TRIG_LOW  = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;

  function automatic int type_lsb(input int pin);
    return (pin % 16) * 2;
  endfunction

  function automatic int ctrl_lsb(input int slot);
    return slot * SL_W;
  endfunction

  function automatic logic trig_hit(input logic [1:0] t, input logic cur,
                                    input logic prev, input logic stb);
    logic h;
    case (trig_e'(t))
      TRIG_HIGH: h = cur;
      TRIG_LOW:  h = ~cur;
      TRIG_RISE: h = stb & cur & ~prev;
      default:   h = stb & ~cur & prev;
    endcase
    return h;
  endfunction
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s0_q, s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q <= '0;
      s1_q <= '0;
    end else begin
      s0_q <= d_i;
      s1_q <= s0_q;
    end
  end

  assign q_o = s1_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPINS-1:0]   lvl_i,
  input  logic               strobe_i,
  input  logic [2*NPINS-1:0] types_i,
  output logic [NPINS-1:0]   hit_o,
  output logic [NPINS-1:0]   edge_o
);
  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        prev_q <= '0;
    else if (strobe_i) prev_q <= lvl_i;
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [1:0] t;
    assign t         = types_i[2*p +: 2];
    assign hit_o[p]  = trig_hit(t, lvl_i[p], prev_q[p], strobe_i);
    assign edge_o[p] = t[1] & hit_o[p];
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int SLOT  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pins_i,
  output logic [NPINS-1:0]  pin_out_o,
  output logic [NPINS-1:0]  pin_oe_o,
  output logic [NPINS-1:0]  pin_ie_o,
  input  logic              samp_a_i,
  input  logic              samp_b_i,
  output logic              irq_o
);
  localparam int CL = ctrl_lsb(SLOT);

  logic [NPINS-1:0]   oe_q, ie_q, dat_q, mask_q, pend_q;
  logic [2*NPINS-1:0] type_q;
  logic               port_en_q, port_sel_q, port_pend_q;

  logic [NPINS-1:0]   lvl, hit, edge_hit, pend_set;
  logic               strobe, irq_raw;
  logic               wr_en, wr_pend, wr_ctrl;
  logic [31:0]        tw_hi, tw_lo, ctrl_word;

  assign wr_en   = bus_sel & bus_wr;
  assign wr_pend = wr_en && bus_addr == A_PEND;
  assign wr_ctrl = wr_en && bus_addr == A_CTRL;
  assign strobe  = port_sel_q ? samp_b_i : samp_a_i;

  gpio_irq_sync #(.W(NPINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pins_i),
    .q_o   (lvl)
  );

  gpio_irq_detect #(.NPINS(NPINS)) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl_i    (lvl),
    .strobe_i (strobe),
    .types_i  (type_q),
    .hit_o    (hit),
    .edge_o   (edge_hit)
  );

  assign pend_set = hit & mask_q;
  assign irq_raw  = port_en_q & (|(pend_q & mask_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q        <= '0;
      ie_q        <= '0;
      dat_q       <= '0;
      mask_q      <= '0;
      pend_q      <= '0;
      type_q      <= '0;
      port_en_q   <= 1'b0;
      port_sel_q  <= 1'b0;
      port_pend_q <= 1'b0;
    end else begin
      if (wr_en && bus_addr == A_OE)   oe_q   <= bus_wdata[NPINS-1:0];
      if (wr_en && bus_addr == A_IE)   ie_q   <= bus_wdata[NPINS-1:0];
      if (wr_en && bus_addr == A_DAT)  dat_q  <= bus_wdata[NPINS-1:0];
      if (wr_en && bus_addr == A_MASK) mask_q <= bus_wdata[NPINS-1:0];
      for (int i = 0; i < NPINS; i++) begin
        if (wr_en && bus_addr == ((i < 16) ? A_TLO : A_THI))
          type_q[2*i +: 2] <= bus_wdata[type_lsb(i) +: 2];
      end
      pend_q <= (pend_q & ~(wr_pend ? bus_wdata[NPINS-1:0] : '0)) | pend_set;
      if (wr_ctrl) begin
        port_en_q  <= bus_wdata[CL+SL_EN];
        port_sel_q <= bus_wdata[CL+SL_SEL];
      end
      port_pend_q <= (port_pend_q & ~(wr_ctrl & bus_wdata[CL+SL_PEND])) | irq_raw;
    end
  end

  always_comb begin
    tw_hi     = '0;
    tw_lo     = '0;
    ctrl_word = '0;
    for (int i = 0; i < NPINS; i++) begin
      if (i < 16) tw_lo[type_lsb(i) +: 2] = type_q[2*i +: 2];
      else        tw_hi[type_lsb(i) +: 2] = type_q[2*i +: 2];
    end
    ctrl_word[CL+SL_EN]   = port_en_q;
    ctrl_word[CL+SL_PEND] = port_pend_q;
    ctrl_word[CL+SL_SEL]  = port_sel_q;
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        A_OE:    bus_rdata = 32'(oe_q);
        A_IE:    bus_rdata = 32'(ie_q);
        A_DAT:   bus_rdata = 32'(lvl);
        A_THI:   bus_rdata = tw_hi;
        A_TLO:   bus_rdata = tw_lo;
        A_MASK:  bus_rdata = 32'(mask_q);
        A_PEND:  bus_rdata = 32'(pend_q);
        default: bus_rdata = ctrl_word;
      endcase
    end
  end

  assign pin_oe_o  = oe_q;
  assign pin_ie_o  = ie_q;
  assign pin_out_o = dat_q & oe_q;
  assign irq_o     = irq_raw;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_pend,
  input logic [31:0]       bus_wdata,
  input logic [NPINS-1:0]  pend_q,
  input logic [NPINS-1:0]  mask_q,
  input logic [NPINS-1:0]  hit,
  input logic [NPINS-1:0]  edge_hit,
  input logic              strobe,
  input logic              port_en_q,
  input logic              port_pend_q,
  input logic              irq_o
);
  assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> port_en_q);

  assert_port_pend_follows_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> port_pend_q);

  assert_pend_set_only_unmasked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(hit & mask_q)) == '0));

  assert_pend_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pend |=> ((~pend_q & $past(pend_q)) == '0));

  assert_pend_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pend |=> ((pend_q & $past(bus_wdata[NPINS-1:0]) & ~$past(hit & mask_q)) == '0));

  assert_edge_on_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_hit) |-> strobe);
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_pend     (wr_pend),
  .bus_wdata   (bus_wdata),
  .pend_q      (pend_q),
  .mask_q      (mask_q),
  .hit         (hit),
  .edge_hit    (edge_hit),
  .strobe      (strobe),
  .port_en_q   (port_en_q),
  .port_pend_q (port_pend_q),
  .irq_o       (irq_o)
);

// File: tb/test_gpio_irq_port.sv
module test_gpio_irq_port;
  localparam int NP   = 20;
  localparam int SL   = 1;
  localparam int CLB  = 5 * SL;
  localparam logic [31:0] ALLP = (32'd1 << NP) - 1;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [2:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [NP-1:0] pins_i = 0, pin_out_o, pin_oe_o, pin_ie_o;
  logic samp_a_i = 1, samp_b_i = 0, irq_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  gpio_irq_port #(.NPINS(NP), .SLOT(SL)) i_gpio_irq_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pins_i(pins_i), .pin_out_o(pin_out_o), .pin_oe_o(pin_oe_o),
    .pin_ie_o(pin_ie_o), .samp_a_i(samp_a_i), .samp_b_i(samp_b_i), .irq_o(irq_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), rv); chk("R1 reg reset", rv, 0);
    end
    chk("R1 outputs", {pin_oe_o, pin_ie_o, pin_out_o, irq_o}, 0);

    // R3 pin read after two edges
    @(negedge clk); pins_i = 20'h5A5A5;
    @(negedge clk); rd(3'd2, rv); chk("R3 one edge", rv, 0);
    @(negedge clk); rd(3'd2, rv); chk("R3 two edges", rv, 32'h5A5A5);
    pins_i = 0; idle(3);

    // R2 enables and data
    wr(3'd0, 32'hF0F0F0F0); wr(3'd1, 32'hFFFABCDE); wr(3'd2, 32'hFFFFFFFF);
    rd(3'd0, rv); chk("R2 oe readback", rv, 32'hF0F0F0F0 & ALLP);
    rd(3'd1, rv); chk("R2 ie readback", rv, 32'hFFFABCDE & ALLP);
    chk("R2 pin_oe", 32'(pin_oe_o), 32'hF0F0F0F0 & ALLP);
    chk("R2 pin_ie", 32'(pin_ie_o), 32'hFFFABCDE & ALLP);
    chk("R2 pin_out", 32'(pin_out_o), 32'hF0F0F0F0 & ALLP);
    wr(3'd0, 0); wr(3'd1, 0);
    chk("R2 release", {pin_oe_o, pin_ie_o, pin_out_o}, 0);

    // R4 type word layout
    wr(3'd3, 32'hFFFFFFFF); wr(3'd4, 32'hFFFFFFFF);
    rd(3'd3, rv); chk("R4 hi word pins16+", rv, 32'h000000FF);
    rd(3'd4, rv); chk("R4 lo word pins0-15", rv, 32'hFFFFFFFF);

    // R9 control slice
    wr(3'd7, 32'hFFFFFFFF);
    rd(3'd7, rv); chk("R9 slice all-ones", rv, 32'h5 << CLB);
    wr(3'd7, 32'h1 << CLB);
    rd(3'd7, rv); chk("R9 enable only", rv, 32'h1 << CLB);

    // R4 R5 R6 R8 sweep over every pin and trigger type
    for (int n = 0; n < NP; n++) begin
      for (int t = 0; t < 4; t++) begin
        logic [NP-1:0] base;
        logic [31:0] bit_n;
        bit_n = 32'd1 << n;
        base  = (t == 1 || t == 3) ? NP'(bit_n) : '0;
        wr(3'd5, 0);
        pins_i = base; idle(4);
        if (n < 16) begin wr(3'd4, 32'(t) << (2*n)); wr(3'd3, 0); end
        else        begin wr(3'd3, 32'(t) << (2*(n-16))); wr(3'd4, 0); end
        wr(3'd6, 32'hFFFFFFFF);
        wr(3'd5, bit_n);
        rd(3'd6, rv); chk("R4 inactive no pending", rv, 0);
        pins_i = base ^ NP'(bit_n); idle(4);
        rd(3'd6, rv); chk(t >= 2 ? "R5 edge sets pending" : "R6 level sets pending", rv, bit_n);
        chk("R10 irq with enable", 32'(irq_o), 1);
        wr(3'd6, 0);
        rd(3'd6, rv); chk("R8 write 0 keeps", rv, bit_n);
        wr(3'd6, bit_n);
        rd(3'd6, rv);
        if (t >= 2) chk("R5 edge cleared stays 0", rv, 0);
        else        chk("R6 level re-sets", rv, bit_n);
        pins_i = base; idle(4);
        wr(3'd6, 32'hFFFFFFFF);
        rd(3'd6, rv); chk("R5 R6 return edge no pending", rv, 0);
      end
    end
    wr(3'd5, 0); wr(3'd3, 0); wr(3'd4, 0); wr(3'd6, 32'hFFFFFFFF);

    // R10 port enable and sticky port pending
    wr(3'd7, 32'h2 << CLB);
    rd(3'd7, rv); chk("R10 disabled and cleared", rv, 0);
    pins_i = 20'h4; idle(4);
    wr(3'd5, 32'h4); idle(2);
    rd(3'd6, rv); chk("R7 unmask sets level pending", rv, 32'h4);
    chk("R10 irq low while disabled", 32'(irq_o), 0);
    rd(3'd7, rv); chk("R10 no port pending disabled", rv, 0);
    wr(3'd7, 32'h1 << CLB);
    chk("R10 irq on enable", 32'(irq_o), 1);
    idle(1);
    rd(3'd7, rv); chk("R10 port pending set", rv, 32'h3 << CLB);
    wr(3'd5, 0);
    chk("R10 irq low when masked", 32'(irq_o), 0);
    rd(3'd7, rv); chk("R10 port pending sticky", rv, 32'h3 << CLB);
    wr(3'd7, 32'h3 << CLB);
    rd(3'd7, rv); chk("R9 port pending w1c", rv, 32'h1 << CLB);

    // R7 masked pin never pends
    pins_i = 20'h2; wr(3'd6, 32'hFFFFFFFF); idle(4);
    rd(3'd6, rv); chk("R7 masked no pending", rv, 0);
    pins_i = 0; idle(4);

    // R11 strobe selection
    wr(3'd7, 32'h5 << CLB);
    wr(3'd4, 32'h2);  // pin 0 rising
    wr(3'd6, 32'hFFFFFFFF);
    wr(3'd5, 32'h1);
    pins_i = 20'h1; idle(6);
    rd(3'd6, rv); chk("R11 no strobe no edge", rv, 0);
    @(negedge clk); samp_b_i = 1;
    @(negedge clk); samp_b_i = 0;
    rd(3'd6, rv); chk("R11 strobe catches edge", rv, 32'h1);
    wr(3'd6, 32'h1);
    @(negedge clk); samp_b_i = 1;
    @(negedge clk); samp_b_i = 0;
    rd(3'd6, rv); chk("R11 edge consumed", rv, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule